// File: doc/BRIEF.md
# Capture Engine Interrupt Status Register

This block holds the 32-bit interrupt status word of a video capture DMA engine. The word combines two kinds of field. Live fields are read-only: a 4-bit status value that the DMA program drives, the DMA run state, the video field parity and the acknowledge result of the last two-wire serial transfer. Sticky fields are eight error and event flags. Each flag latches a single-cycle pulse from the DMA sequencer, the PCI side or the pixel FIFO, and stays set until software clears it.

Software reads the status word and writes the same value back. Each 1 in the written data clears the matching sticky flag. A second register holds a 32-bit mask, and the interrupt output is raised while any unmasked sticky flag is set. When an instruction fetch hits a data parity error and parity error response is enabled, the block stops the DMA run state in that same cycle.

Top module: `vcap_irq_status`

## Requirements
- R1: After reset every sticky flag, the 4-bit program status, the run state, the acknowledge bit and the mask register are 0, and `irq` is low.
- R2: Status bits 31:28 hold the program status. In each cycle, bit n is set when `dma_stat_set[n]` is high and cleared when `dma_stat_clr[n]` is high. When both are high in the same cycle, set wins. These bits never affect `irq`.
- R3: Status bit 27 reads the registered run state. A pulse on `dma_run_set` sets it and a pulse on `dma_run_clr` clears it, and set wins over clear. Status bit 24 reads `field_even` directly (0 is odd, 1 is even).
- R4: Status bit 25 takes the value of `i2c_ack` on every cycle in which `i2c_done` is high, and holds its value in all other cycles.
- R5: Status bits 26, 23:20 and 11:0 always read 0. A write to the status word leaves bits 31:20 and 11:0 unchanged.
- R6: The sticky flags sit at bits 19:12 and have these set sources. Bit 19 is `sync_ovf` or `sync_mismatch`. Bit 18 is `bad_opcode` or `bad_sync_stat`. Bit 17 is `master_abort` or `target_abort`. Bit 15 is `pci_perr`. Bit 14 is `fifo_resync`. Bit 13 is `fifo_ovr_term`. Bit 12 is `fifo_ovr_drop`. A flag becomes visible one cycle after its pulse.
- R7: A write to the status word clears each sticky flag whose bit in `bus_wdata` is 1. A sticky flag written with 0 keeps its value.
- R8: When a sticky flag's set event and its write-1 clear fall in the same cycle, the flag ends up set.
- R9: Bit 16 is set by `fetch_perr` only while `perr_resp_en` is high. Bit 15 is set by `pci_perr` whatever the value of `perr_resp_en`.
- R10: In any cycle in which `fetch_perr` and `perr_resp_en` are both high, `dma_run` is low in that same cycle. The run state reads 0 from the next cycle on, and this takes priority over `dma_run_set`.
- R11: The mask register is at offset 1. All 32 of its bits can be read and written. `irq` is high exactly when some sticky flag i (bits 19:12) is set and mask bit i is set. No live field contributes to `irq`.
- R12: `bus_rdata` shows the addressed register in the same cycle as `bus_rd`: status at offset 0, mask at offset 1, and 0 at every other offset. It is 0 while `bus_rd` is low. Writes to offsets other than 0 and 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset (0 status, 1 mask) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| dma_stat_set | input | 4 | Per-bit set of program status |
| dma_stat_clr | input | 4 | Per-bit clear of program status |
| dma_run_set | input | 1 | Start pulse for run state |
| dma_run_clr | input | 1 | Stop pulse for run state |
| dma_run | output | 1 | Run state, forced low by a fetch parity kill |
| field_even | input | 1 | Current field parity |
| i2c_done | input | 1 | Serial transfer finished pulse |
| i2c_ack | input | 1 | Acknowledge result, valid with i2c_done |
| sync_ovf | input | 1 | End-of-line sync counter overflow |
| sync_mismatch | input | 1 | Sync code mismatch |
| bad_opcode | input | 1 | Reserved opcode fetched |
| bad_sync_stat | input | 1 | Reserved sync status fetched |
| master_abort | input | 1 | Master abort received |
| target_abort | input | 1 | Target abort received |
| fetch_perr | input | 1 | Data parity error on instruction fetch |
| perr_resp_en | input | 1 | Parity error response enable level |
| pci_perr | input | 1 | Any bus parity error |
| fifo_resync | input | 1 | FIFO data stream resynchronised |
| fifo_ovr_term | input | 1 | FIFO overrun, transaction terminated |
| fifo_ovr_drop | input | 1 | FIFO overrun, words dropped |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the cycle where a sticky event and a write-1 clear hit the same flag. A design that lets the clear win loses the event, and the flag then reads 0. It drives fetch parity errors with the response enable both on and off. A design that ignores the enable sets bit 16 when it should not, and one that registers the kill leaves `dma_run` high for a cycle. Random writes with set bits in the live and reserved positions, and writes to unused offsets, expose any decode that lets software disturb read-only fields or the mask. Read-back of the value software has just cleared confirms that flags written with 0 survive.

// File: rtl/vcap_irq_pkg.sv
package vcap_irq_pkg;

    localparam int STAT_W     = 32;
    localparam int RISC_W     = 4;
    localparam int STICKY_W   = 8;
    localparam int RISC_LSB   = 28;
    localparam int RUN_BIT    = 27;
    localparam int RACK_BIT   = 25;
    localparam int FIELD_BIT  = 24;
    localparam int STICKY_LSB = 12;

    // Sticky flag index, counted from STICKY_LSB upward
    typedef enum logic [2:0] {
        EV_FIFO_DROP  = 3'd0,
        EV_FIFO_TERM  = 3'd1,
        EV_RESYNC     = 3'd2,
        EV_PCI_PERR   = 3'd3,
        EV_FETCH_PERR = 3'd4,
        EV_ABORT      = 3'd5,
        EV_OPCODE     = 3'd6,
        EV_SYNC       = 3'd7
    } ev_idx_e;

endpackage

// File: rtl/vcap_irq_sticky.sv
module vcap_irq_sticky #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    typedef struct packed {
        logic [N-1:0] flags;
    } sticky_t;

    sticky_t state_d, state_q;
    logic [N-1:0] next_bit;

    // One independent cell per flag; set has priority over clear
    for (genvar g = 0; g < N; g++) begin : g_cell
        always_comb begin
            if (set_i[g]) begin
                next_bit[g] = 1'b1;
            end else if (clr_i[g]) begin
                next_bit[g] = 1'b0;
            end else begin
                next_bit[g] = state_q.flags[g];
            end
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.flags = next_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.flags;

endmodule

// File: rtl/vcap_irq_live.sv
module vcap_irq_live #(
    parameter int RISC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RISC_W-1:0] risc_set_i,
    input  logic [RISC_W-1:0] risc_clr_i,
    input  logic              run_set_i,
    input  logic              run_clr_i,
    input  logic              run_kill_i,
    input  logic              i2c_done_i,
    input  logic              i2c_ack_i,
    output logic [RISC_W-1:0] risc_o,
    output logic              run_q_o,
    output logic              run_o,
    output logic              rack_o
);

    typedef struct packed {
        logic [RISC_W-1:0] risc;
        logic              run;
        logic              rack;
    } live_t;

    live_t state_d, state_q;

    always_comb begin
        state_d = state_q;

        for (int i = 0; i < RISC_W; i++) begin
            if (risc_set_i[i]) begin
                state_d.risc[i] = 1'b1;
            end else if (risc_clr_i[i]) begin
                state_d.risc[i] = 1'b0;
            end
        end

        // Kill outranks start, start outranks stop
        if (run_kill_i) begin
            state_d.run = 1'b0;
        end else if (run_set_i) begin
            state_d.run = 1'b1;
        end else if (run_clr_i) begin
            state_d.run = 1'b0;
        end

        if (i2c_done_i) begin
            state_d.rack = i2c_ack_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign risc_o  = state_q.risc;
    assign run_q_o = state_q.run;
    assign run_o   = state_q.run & ~run_kill_i;
    assign rack_o  = state_q.rack;

endmodule

// File: rtl/vcap_irq_regif.sv
module vcap_irq_regif #(
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 32,
    parameter int STICKY_W   = 8,
    parameter int STICKY_LSB = 12,
    parameter int STAT_OFS   = 0,
    parameter int MASK_OFS   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_i,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [DATA_W-1:0]   status_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [DATA_W-1:0]   mask_o,
    output logic [STICKY_W-1:0] stat_clr_o
);

    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } regif_t;

    regif_t state_d, state_q;
    logic   hit_stat;
    logic   hit_mask;

    always_comb begin
        hit_stat = (addr_i == STAT_A);
        hit_mask = (addr_i == MASK_A);

        state_d = state_q;
        if (wr_i && hit_mask) begin
            state_d.mask = wdata_i;
        end

        stat_clr_o = '0;
        if (wr_i && hit_stat) begin
            stat_clr_o = wdata_i[STICKY_LSB +: STICKY_W];
        end

        rdata_o = '0;
        if (rd_i) begin
            if (hit_stat) begin
                rdata_o = status_i;
            end else if (hit_mask) begin
                rdata_o = state_q.mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.mask;

endmodule

// File: rtl/vcap_irq_status.sv
module vcap_irq_status
    import vcap_irq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        dma_stat_set,
    input  logic [3:0]        dma_stat_clr,
    input  logic              dma_run_set,
    input  logic              dma_run_clr,
    output logic              dma_run,
    input  logic              field_even,
    input  logic              i2c_done,
    input  logic              i2c_ack,
    input  logic              sync_ovf,
    input  logic              sync_mismatch,
    input  logic              bad_opcode,
    input  logic              bad_sync_stat,
    input  logic              master_abort,
    input  logic              target_abort,
    input  logic              fetch_perr,
    input  logic              perr_resp_en,
    input  logic              pci_perr,
    input  logic              fifo_resync,
    input  logic              fifo_ovr_term,
    input  logic              fifo_ovr_drop,
    output logic              irq
);

    logic [STICKY_W-1:0] sticky_set;
    logic [STICKY_W-1:0] sticky_clr;
    logic [STICKY_W-1:0] sticky_q;
    logic [RISC_W-1:0]   risc_q;
    logic                run_q;
    logic                rack_q;
    logic                fetch_kill;
    logic [STAT_W-1:0]   status_word;
    logic [STAT_W-1:0]   mask_q;

    always_comb begin
        fetch_kill = fetch_perr & perr_resp_en;

        sticky_set                     = '0;
        sticky_set[int'(EV_FIFO_DROP)]  = fifo_ovr_drop;
        sticky_set[int'(EV_FIFO_TERM)]  = fifo_ovr_term;
        sticky_set[int'(EV_RESYNC)]     = fifo_resync;
        sticky_set[int'(EV_PCI_PERR)]   = pci_perr;
        sticky_set[int'(EV_FETCH_PERR)] = fetch_kill;
        sticky_set[int'(EV_ABORT)]      = master_abort | target_abort;
        sticky_set[int'(EV_OPCODE)]     = bad_opcode | bad_sync_stat;
        sticky_set[int'(EV_SYNC)]       = sync_ovf | sync_mismatch;
    end

    vcap_irq_sticky #(
        .N (STICKY_W)
    ) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (sticky_set),
        .clr_i   (sticky_clr),
        .flags_o (sticky_q)
    );

    vcap_irq_live #(
        .RISC_W (RISC_W)
    ) u_live (
        .clk        (clk),
        .rst_n      (rst_n),
        .risc_set_i (dma_stat_set),
        .risc_clr_i (dma_stat_clr),
        .run_set_i  (dma_run_set),
        .run_clr_i  (dma_run_clr),
        .run_kill_i (fetch_kill),
        .i2c_done_i (i2c_done),
        .i2c_ack_i  (i2c_ack),
        .risc_o     (risc_q),
        .run_q_o    (run_q),
        .run_o      (dma_run),
        .rack_o     (rack_q)
    );

    always_comb begin
        status_word                               = '0;
        status_word[RISC_LSB +: RISC_W]           = risc_q;
        status_word[RUN_BIT]                      = run_q;
        status_word[RACK_BIT]                     = rack_q;
        status_word[FIELD_BIT]                    = field_even;
        status_word[STICKY_LSB +: STICKY_W]       = sticky_q;
    end

    vcap_irq_regif #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (STAT_W),
        .STICKY_W   (STICKY_W),
        .STICKY_LSB (STICKY_LSB),
        .STAT_OFS   (0),
        .MASK_OFS   (1)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (bus_rd),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .status_i   (status_word),
        .rdata_o    (bus_rdata),
        .mask_o     (mask_q),
        .stat_clr_o (sticky_clr)
    );

    assign irq = |(sticky_q & mask_q[STICKY_LSB +: STICKY_W]);

endmodule

// File: rtl/vcap_irq_status_chk.sv
module vcap_irq_status_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        sticky_set,
    input logic [7:0]        sticky_clr,
    input logic [7:0]        sticky_q,
    input logic [31:0]       mask_q,
    input logic              irq,
    input logic              fetch_kill,
    input logic              dma_run,
    input logic              run_q,
    input logic              i2c_done,
    input logic              i2c_ack,
    input logic              rack_q
);

    AST_STICKY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_set == '0 && sticky_clr == '0) |=> $stable(sticky_q)); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_clr & ~sticky_set) != '0) |=> ((sticky_q & $past(sticky_clr & ~sticky_set)) == '0)); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_set != '0) |=> ((sticky_q & $past(sticky_set)) == $past(sticky_set))); // R8

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[19:12] == '0) |-> !irq); // R11

    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_q & mask_q[19:12]) != '0) |-> irq); // R11

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0) |-> (bus_rdata[26] == 1'b0 && bus_rdata[23:20] == 4'd0 && bus_rdata[11:0] == 12'd0)); // R5

    AST_KILL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kill |-> !dma_run); // R10

    AST_KILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_kill |=> !run_q); // R10

    AST_RACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_done |=> (rack_q == $past(i2c_ack))); // R4

    AST_RACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !i2c_done |=> $stable(rack_q)); // R4

endmodule

bind vcap_irq_status vcap_irq_status_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .sticky_set (sticky_set),
    .sticky_clr (sticky_clr),
    .sticky_q   (sticky_q),
    .mask_q     (mask_q),
    .irq        (irq),
    .fetch_kill (fetch_kill),
    .dma_run    (dma_run),
    .run_q      (run_q),
    .i2c_done   (i2c_done),
    .i2c_ack    (i2c_ack),
    .rack_q     (rack_q)
);

// File: tb/vcap_irq_status_tb.sv
module vcap_irq_status_tb;

    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [3:0]        dma_stat_set = '0;
    logic [3:0]        dma_stat_clr = '0;
    logic              dma_run_set = 1'b0;
    logic              dma_run_clr = 1'b0;
    logic              dma_run;
    logic              field_even = 1'b0;
    logic              i2c_done = 1'b0;
    logic              i2c_ack = 1'b0;
    logic [10:0]       ev = '0;
    logic              perr_resp_en = 1'b0;
    logic              irq;

    // ev: 10 sync_ovf, 9 sync_mismatch, 8 bad_opcode, 7 bad_sync_stat,
    //     6 master_abort, 5 target_abort, 4 fetch_perr, 3 pci_perr,
    //     2 fifo_resync, 1 fifo_ovr_term, 0 fifo_ovr_drop
    vcap_irq_status #(.ADDR_W(ADDR_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .dma_stat_set  (dma_stat_set),
        .dma_stat_clr  (dma_stat_clr),
        .dma_run_set   (dma_run_set),
        .dma_run_clr   (dma_run_clr),
        .dma_run       (dma_run),
        .field_even    (field_even),
        .i2c_done      (i2c_done),
        .i2c_ack       (i2c_ack),
        .sync_ovf      (ev[10]),
        .sync_mismatch (ev[9]),
        .bad_opcode    (ev[8]),
        .bad_sync_stat (ev[7]),
        .master_abort  (ev[6]),
        .target_abort  (ev[5]),
        .fetch_perr    (ev[4]),
        .perr_resp_en  (perr_resp_en),
        .pci_perr      (ev[3]),
        .fifo_resync   (ev[2]),
        .fifo_ovr_term (ev[1]),
        .fifo_ovr_drop (ev[0]),
        .irq           (irq)
    );

    always #2.5 clk = ~clk;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    // Pending stimulus, applied at the next falling edge
    logic [ADDR_W-1:0] nx_addr;
    logic              nx_rd, nx_wr, nx_rset, nx_rclr, nx_field, nx_done, nx_ack, nx_resp;
    logic [31:0]       nx_wdata;
    logic [3:0]        nx_sset, nx_sclr;
    logic [10:0]       nx_ev;

    // Reference state
    logic [3:0]  m_risc   = '0;
    logic        m_run    = 1'b0;
    logic        m_rack   = 1'b0;
    logic [7:0]  m_sticky = '0;
    logic [31:0] m_mask   = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ev_to_set(input logic [10:0] e, input logic resp);
        logic [7:0] s;
        s[0] = e[0];
        s[1] = e[1];
        s[2] = e[2];
        s[3] = e[3];
        s[4] = e[4] & resp;
        s[5] = e[6] | e[5];
        s[6] = e[8] | e[7];
        s[7] = e[10] | e[9];
        return s;
    endfunction

    task automatic idle();
        nx_addr = '0; nx_rd = 1'b1; nx_wr = 1'b0; nx_wdata = '0;
        nx_sset = '0; nx_sclr = '0; nx_rset = 1'b0; nx_rclr = 1'b0;
        nx_field = field_even; nx_done = 1'b0; nx_ack = 1'b0;
        nx_ev = '0; nx_resp = 1'b0;
    endtask

    task automatic cycle();
        logic [31:0] exp_rd;
        logic [7:0]  setv;
        logic [7:0]  clrv;
        logic        kill;
        @(negedge clk);
        bus_addr = nx_addr; bus_rd = nx_rd; bus_wr = nx_wr; bus_wdata = nx_wdata;
        dma_stat_set = nx_sset; dma_stat_clr = nx_sclr;
        dma_run_set = nx_rset; dma_run_clr = nx_rclr; field_even = nx_field;
        i2c_done = nx_done; i2c_ack = nx_ack; ev = nx_ev; perr_resp_en = nx_resp;
        #1;
        kill = nx_ev[4] & nx_resp;
        if (nx_rd && nx_addr == 2'd0) begin
            check("R2 program status bits", 32'(bus_rdata[31:28]), 32'(m_risc));
            check("R3 run bit 27", 32'(bus_rdata[27]), 32'(m_run));
            check("R3 field bit 24", 32'(bus_rdata[24]), 32'(nx_field));
            check("R4 ack bit 25", 32'(bus_rdata[25]), 32'(m_rack));
            check("R5 reserved bits", {bus_rdata[26], bus_rdata[23:20], bus_rdata[11:0]}, 32'd0);
            check("R6/R7/R8/R9 sticky bits", 32'(bus_rdata[19:12]), 32'(m_sticky));
        end else begin
            if (!nx_rd) exp_rd = '0;
            else if (nx_addr == 2'd1) exp_rd = m_mask;
            else exp_rd = '0;
            check("R12 read data", bus_rdata, exp_rd);
        end
        check("R11 irq", 32'(irq), 32'(|(m_sticky & m_mask[19:12])));
        check("R10 dma_run", 32'(dma_run), 32'(m_run & ~kill));

        // Advance the reference to the state after the coming rising edge
        setv = ev_to_set(nx_ev, nx_resp);
        clrv = (nx_wr && nx_addr == 2'd0) ? nx_wdata[19:12] : 8'd0;
        m_sticky = (m_sticky & ~clrv) | setv;
        m_risc   = (m_risc & ~nx_sclr) | nx_sset;
        if (kill) m_run = 1'b0;
        else if (nx_rset) m_run = 1'b1;
        else if (nx_rclr) m_run = 1'b0;
        if (nx_done) m_rack = nx_ack;
        if (nx_wr && nx_addr == 2'd1) m_mask = nx_wdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7411));
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of status, mask and outputs
        idle(); cycle();
        check("R1 reset sticky", {24'd0, m_sticky}, 32'd0);
        idle(); nx_addr = 2'd1; cycle();

        // R11: mask write and full read-back
        idle(); nx_wr = 1'b1; nx_addr = 2'd1; nx_wdata = 32'hFFFF_FFFF; cycle();
        idle(); nx_addr = 2'd1; cycle();

        // R9: fetch parity error without response enable leaves bit 16 clear
        idle(); nx_ev[4] = 1'b1; nx_resp = 1'b0; cycle();
        idle(); cycle();
        // R9: bus parity error sets bit 15 with response disabled
        idle(); nx_ev[3] = 1'b1; cycle();
        idle(); cycle();

        // R10: start, then kill by fetch parity error with start also pulsed
        idle(); nx_rset = 1'b1; cycle();
        idle(); nx_ev[4] = 1'b1; nx_resp = 1'b1; nx_rset = 1'b1; cycle();
        idle(); cycle();

        // R7: read back then write the same word; write 0 keeps bits
        idle(); nx_ev = 11'b101_0100_0001; cycle();
        idle(); nx_wr = 1'b1; nx_wdata = {12'hFFF, m_sticky & 8'h0F, 12'hFFF}; cycle();
        idle(); cycle();
        idle(); nx_wr = 1'b1; nx_wdata = {12'd0, m_sticky, 12'd0}; cycle();
        idle(); cycle();

        // R8: set and clear of the same flag in one cycle
        idle(); nx_ev[2] = 1'b1; nx_wr = 1'b1; nx_wdata = 32'h000F_F000; cycle();
        idle(); cycle();

        // R2: set and clear of program status in one cycle
        idle(); nx_sset = 4'b1010; nx_sclr = 4'b1111; cycle();
        idle(); nx_sclr = 4'b0010; cycle();
        idle(); cycle();

        // R4: ack result latched only on done
        idle(); nx_done = 1'b1; nx_ack = 1'b1; cycle();
        idle(); nx_ack = 1'b0; cycle();
        idle(); nx_done = 1'b1; nx_ack = 1'b0; cycle();
        idle(); cycle();

        // R12: unused offsets ignore writes and read 0; no read gives 0
        idle(); nx_wr = 1'b1; nx_addr = 2'd2; nx_wdata = 32'h1234_5678; cycle();
        idle(); nx_wr = 1'b1; nx_addr = 2'd3; nx_wdata = 32'hFFFF_FFFF; cycle();
        idle(); nx_addr = 2'd3; cycle();
        idle(); nx_rd = 1'b0; cycle();
        idle(); nx_addr = 2'd1; cycle();

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            idle();
            nx_rd    = ($urandom % 4) != 0;
            nx_addr  = ADDR_W'($urandom % 4);
            nx_wr    = ($urandom % 5) == 0;
            nx_wdata = $urandom;
            if (nx_wr && nx_addr == 2'd0 && ($urandom % 2) == 0)
                nx_wdata = {$urandom} & {12'hFFF, m_sticky, 12'hFFF};
            for (int b = 0; b < 11; b++) nx_ev[b] = ($urandom % 10) == 0;
            nx_resp  = $urandom % 2;
            nx_sset  = 4'($urandom) & 4'($urandom);
            nx_sclr  = 4'($urandom) & 4'($urandom);
            nx_rset  = ($urandom % 6) == 0;
            nx_rclr  = ($urandom % 8) == 0;
            nx_field = $urandom % 2;
            nx_done  = ($urandom % 7) == 0;
            nx_ack   = $urandom % 2;
            cycle();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule